// File: doc/BRIEF.md
# Register Rename Buffer Tracker

This block keeps a pool of rename entries for one architectural register file. Each entry runs a five-state machine: free, pending-newest, pending-stale, done-newest or done-stale. A dispatch that writes a register claims the free entry with the lowest index and receives that entry's index as its tag.

Claiming an entry for a register demotes any older entry for the same register from newest to stale. A source lookup therefore finds the current mapping by comparing the register index against the newest entries only, with no separate map table. When the producer finishes, the entry is marked done and stores the result. A writeback releases a done entry, and a flush releases every entry still in the pool.

Allocation uses a valid/ready handshake. An entry is claimed only in a cycle where `alloc_valid` and `alloc_ready` are both high. A low `alloc_ready` is the dispatch stall signal: the pool is full or a flush is in progress, and the dispatcher must hold its request. The finish, writeback, flush and lookup pins are plain control pins.

Top module: `rnb_tracker`

## Requirements
- R1: After reset every entry is free, `alloc_ready` is high and a lookup of any register reports a miss (`lk_hit` = 0).
- R2: A granted allocation returns as `alloc_tag` the lowest-numbered free entry. From the next cycle a lookup of that register hits with that tag and with `lk_ready` = 0.
- R3: While no entry is free, `alloc_ready` is low. An `alloc_valid` asserted then claims nothing, so a lookup of the requested register still misses.
- R4: A later allocation of the same register supersedes the older entry. Lookup then returns the newer tag, and at most one newest entry exists per register.
- R5: A finish on a pending entry stores `fin_data` and marks the entry done. For the newest entry, lookup then gives `lk_ready` = 1 and `lk_value` equal to that data. A finish on a stale entry leaves the lookup result unchanged.
- R6: A writeback on a done entry raises `wb_ok` in the same cycle, presents the entry's register index and value, and frees the entry on the next edge. A writeback on an entry that is not done gives `wb_ok` = 0 and changes nothing.
- R7: A flush frees every entry on the next edge and holds `alloc_ready` low in its own cycle.
- R8: When a writeback and a flush occur in the same cycle, the writeback still completes: `wb_ok` is high and the value is presented.
- R9: Once the newest entry of a register is written back, a lookup of that register misses.
- R10: A finish aimed at a free entry is ignored. An entry allocated later still shows `lk_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests an entry |
| alloc_ready | output | 1 | Entry available and no flush; low means stall |
| alloc_areg | input | 5 | Destination register to be renamed |
| alloc_tag | output | TAG_W | Entry granted to the request |
| fin_en | input | 1 | Producer finished |
| fin_tag | input | TAG_W | Entry of the finished producer |
| fin_data | input | DATA_W | Result value |
| wb_en | input | 1 | Writeback request |
| wb_tag | input | TAG_W | Entry to write back |
| wb_ok | output | 1 | Entry was done; writeback accepted |
| wb_areg | output | 5 | Register index of the written-back entry |
| wb_value | output | DATA_W | Value of the written-back entry |
| flush | input | 1 | Discard all entries |
| lk_areg | input | 5 | Source register to look up |
| lk_hit | output | 1 | A newest entry maps this register |
| lk_tag | output | TAG_W | Tag of that entry |
| lk_ready | output | 1 | That entry holds its result |
| lk_value | output | DATA_W | Stored result |

## Verification
The assertions assume the dispatcher raises `alloc_valid` only as the handshake allows. They also assume finish and writeback tags are below the entry count, and that a finish names an entry whose producer is still outstanding. The bench keeps to these rules: it uses tags from a reference list of live entries, and it tries a stalled allocation only to observe that nothing changes. The only stray finish it drives targets a free entry, to cover R10.

// File: rtl/rnb_pkg.sv
package rnb_pkg;
  typedef enum logic [2:0] {
    SLOT_FREE        = 3'd0,
    SLOT_PEND_NEWEST = 3'd1,
    SLOT_PEND_STALE  = 3'd2,
    SLOT_DONE_NEWEST = 3'd3,
    SLOT_DONE_STALE  = 3'd4
  } slot_state_e;

  function automatic logic is_newest(slot_state_e s);
    return (s == SLOT_PEND_NEWEST) || (s == SLOT_DONE_NEWEST);
  endfunction

  function automatic logic is_done(slot_state_e s);
    return (s == SLOT_DONE_NEWEST) || (s == SLOT_DONE_STALE);
  endfunction

  function automatic logic is_pending(slot_state_e s);
    return (s == SLOT_PEND_NEWEST) || (s == SLOT_PEND_STALE);
  endfunction
endpackage

// File: rtl/rnb_slot.sv
module rnb_slot
  import rnb_pkg::*;
#(
  parameter int AREG_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic [AREG_W-1:0] claim_areg,
  input  logic              demote,
  input  logic              finish,
  input  logic [DATA_W-1:0] finish_data,
  input  logic              retire,
  input  logic              flush,
  output slot_state_e       state,
  output logic [AREG_W-1:0] areg,
  output logic [DATA_W-1:0] data
);
  slot_state_e st_nx;
  logic        fin_ok;

  assign fin_ok = finish && is_pending(state) && !flush;

  always_comb begin
    st_nx = state;
    if (retire && is_done(state)) st_nx = SLOT_FREE;
    else if (flush)               st_nx = SLOT_FREE;
    else if (claim)               st_nx = SLOT_PEND_NEWEST;
    else begin
      unique case (state)
        SLOT_PEND_NEWEST:
          if (fin_ok) st_nx = demote ? SLOT_DONE_STALE : SLOT_DONE_NEWEST;
          else        st_nx = demote ? SLOT_PEND_STALE : SLOT_PEND_NEWEST;
        SLOT_PEND_STALE:
          if (fin_ok) st_nx = SLOT_DONE_STALE;
        SLOT_DONE_NEWEST:
          if (demote) st_nx = SLOT_DONE_STALE;
        default: st_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_FREE;
      areg  <= '0;
      data  <= '0;
    end else begin
      state <= st_nx;
      if (claim)  areg <= claim_areg;
      if (fin_ok) data <= finish_data;
    end
  end
endmodule

// File: rtl/rnb_pick.sv
module rnb_pick #(
  parameter int N     = 12,
  parameter int TAG_W = 4
) (
  input  logic [N-1:0]     free_vec,
  output logic             any,
  output logic [TAG_W-1:0] idx
);
  always_comb begin
    any = |free_vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) idx = TAG_W'(i);
    end
  end
endmodule

// File: rtl/rnb_find.sv
module rnb_find #(
  parameter int N      = 12,
  parameter int TAG_W  = 4,
  parameter int AREG_W = 5
) (
  input  logic [N-1:0]      newest_vec,
  input  logic [AREG_W-1:0] areg_tab [N],
  input  logic [AREG_W-1:0] key,
  output logic              hit,
  output logic [TAG_W-1:0]  idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (newest_vec[i] && areg_tab[i] == key) begin
        hit = 1'b1;
        idx = TAG_W'(i);
      end
    end
  end
endmodule

// File: rtl/rnb_tracker.sv
module rnb_tracker
  import rnb_pkg::*;
#(
  parameter int N      = 12,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [AREG_W-1:0] alloc_areg,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              fin_en,
  input  logic [TAG_W-1:0]  fin_tag,
  input  logic [DATA_W-1:0] fin_data,
  input  logic              wb_en,
  input  logic [TAG_W-1:0]  wb_tag,
  output logic              wb_ok,
  output logic [AREG_W-1:0] wb_areg,
  output logic [DATA_W-1:0] wb_value,
  input  logic              flush,
  input  logic [AREG_W-1:0] lk_areg,
  output logic              lk_hit,
  output logic [TAG_W-1:0]  lk_tag,
  output logic              lk_ready,
  output logic [DATA_W-1:0] lk_value
);
  slot_state_e       st_q      [N];
  logic [AREG_W-1:0] slot_areg [N];
  logic [DATA_W-1:0] slot_data [N];
  logic [N-1:0]      free_vec, newest_vec, done_vec, claim_vec, demote_vec, fin_vec, wb_vec;
  logic              any_free, fire;
  logic [TAG_W-1:0]  pick_idx;

  assign alloc_ready = any_free && !flush;
  assign fire        = alloc_valid && alloc_ready;
  assign alloc_tag   = pick_idx;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign free_vec[g]   = (st_q[g] == SLOT_FREE);
    assign newest_vec[g] = is_newest(st_q[g]);
    assign done_vec[g]   = is_done(st_q[g]);
    assign claim_vec[g]  = fire && (pick_idx == TAG_W'(g));
    assign demote_vec[g] = fire && newest_vec[g] && (slot_areg[g] == alloc_areg);
    assign fin_vec[g]    = fin_en && (fin_tag == TAG_W'(g));
    assign wb_vec[g]     = wb_en && (wb_tag == TAG_W'(g));

    rnb_slot #(.AREG_W(AREG_W), .DATA_W(DATA_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .claim       (claim_vec[g]),
      .claim_areg  (alloc_areg),
      .demote      (demote_vec[g]),
      .finish      (fin_vec[g]),
      .finish_data (fin_data),
      .retire      (wb_vec[g]),
      .flush       (flush),
      .state       (st_q[g]),
      .areg        (slot_areg[g]),
      .data        (slot_data[g])
    );
  end

  rnb_pick #(.N(N), .TAG_W(TAG_W)) u_pick (
    .free_vec (free_vec),
    .any      (any_free),
    .idx      (pick_idx)
  );

  rnb_find #(.N(N), .TAG_W(TAG_W), .AREG_W(AREG_W)) u_find (
    .newest_vec (newest_vec),
    .areg_tab   (slot_areg),
    .key        (lk_areg),
    .hit        (lk_hit),
    .idx        (lk_tag)
  );

  always_comb begin
    lk_ready = 1'b0;
    lk_value = '0;
    wb_ok    = 1'b0;
    wb_areg  = '0;
    wb_value = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_hit && lk_tag == TAG_W'(i)) begin
        lk_ready = done_vec[i];
        lk_value = slot_data[i];
      end
      if (wb_vec[i] && done_vec[i]) begin
        wb_ok    = 1'b1;
        wb_areg  = slot_areg[i];
        wb_value = slot_data[i];
      end
    end
  end
endmodule

// File: rtl/rnb_tracker_chk.sv
module rnb_tracker_chk
  import rnb_pkg::*;
#(
  parameter int N      = 12,
  parameter int AREG_W = 5,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [AREG_W-1:0] alloc_areg,
  input logic [TAG_W-1:0]  alloc_tag,
  input logic              wb_ok,
  input logic [TAG_W-1:0]  wb_tag,
  input logic              lk_hit,
  input logic              lk_ready,
  input logic [TAG_W-1:0]  lk_tag,
  input logic [AREG_W-1:0] lk_areg,
  input slot_state_e       st_q      [N],
  input logic [AREG_W-1:0] slot_areg [N]
);
  logic [N-1:0] same_reg_newest;
  logic         all_busy, all_free;

  always_comb begin
    all_busy = 1'b1;
    all_free = 1'b1;
    for (int i = 0; i < N; i++) begin
      same_reg_newest[i] = is_newest(st_q[i]) && (slot_areg[i] == lk_areg);
      if (st_q[i] == SLOT_FREE) all_busy = 1'b0;
      else                      all_free = 1'b0;
    end
  end

  // R2
  grant_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |-> st_q[alloc_tag] == SLOT_FREE);

  // R2
  grant_becomes_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> st_q[$past(alloc_tag)] == SLOT_PEND_NEWEST);

  // R3
  full_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_busy |-> !alloc_ready);

  // R4
  single_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(same_reg_newest) <= 1);

  // R5
  ready_means_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_ready) |-> st_q[lk_tag] == SLOT_DONE_NEWEST);

  // R6
  wb_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ok |=> st_q[$past(wb_tag)] == SLOT_FREE);

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> all_free);
endmodule

bind rnb_tracker rnb_tracker_chk #(.N(N), .AREG_W(AREG_W), .TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_areg  (alloc_areg),
  .alloc_tag   (alloc_tag),
  .wb_ok       (wb_ok),
  .wb_tag      (wb_tag),
  .lk_hit      (lk_hit),
  .lk_ready    (lk_ready),
  .lk_tag      (lk_tag),
  .lk_areg     (lk_areg),
  .st_q        (st_q),
  .slot_areg   (slot_areg)
);

// File: tb/tb_rnb_tracker.sv
module tb_rnb_tracker;
  localparam int N = 12;
  localparam int TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready;
  logic [4:0] alloc_areg = 0;
  logic [TW-1:0] alloc_tag;
  logic fin_en = 0;
  logic [TW-1:0] fin_tag = 0;
  logic [31:0] fin_data = 0;
  logic wb_en = 0, wb_ok;
  logic [TW-1:0] wb_tag = 0;
  logic [4:0] wb_areg;
  logic [31:0] wb_value;
  logic flush = 0;
  logic [4:0] lk_areg = 0;
  logic lk_hit, lk_ready;
  logic [TW-1:0] lk_tag;
  logic [31:0] lk_value;

  always #5 clk = ~clk;

  rnb_tracker dut (.*);

  typedef struct {
    int          kind;  // 0 lookup, 1 alloc, 2 writeback
    logic        flag;
    logic [TW-1:0] tag;
    logic        rdy;
    logic [31:0] val;
    logic [4:0]  ar;
    string       req;
  } exp_t;

  exp_t q[$];
  int pending = 0;
  int n_chk = 0, n_bad = 0;

  task automatic push(exp_t e);
    q.push_back(e);
    pending++;
    wait (pending == 0);
  endtask

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      exp_t e;
      wait (pending > 0);
      #1;
      e = q.pop_front();
      n_chk++;
      case (e.kind)
        0: if (lk_hit !== e.flag ||
               (e.flag && (lk_tag !== e.tag || lk_ready !== e.rdy ||
                           (e.rdy && lk_value !== e.val)))) begin
             n_bad++;
             $display("FAIL %s lookup: hit=%b tag=%0d rdy=%b val=%h, expected hit=%b tag=%0d rdy=%b val=%h",
                      e.req, lk_hit, lk_tag, lk_ready, lk_value, e.flag, e.tag, e.rdy, e.val);
           end
        1: if (alloc_ready !== e.flag || (e.flag && alloc_tag !== e.tag)) begin
             n_bad++;
             $display("FAIL %s alloc: ready=%b tag=%0d, expected ready=%b tag=%0d",
                      e.req, alloc_ready, alloc_tag, e.flag, e.tag);
           end
        default: if (wb_ok !== e.flag ||
                     (e.flag && (wb_areg !== e.ar || wb_value !== e.val))) begin
             n_bad++;
             $display("FAIL %s writeback: ok=%b areg=%0d val=%h, expected ok=%b areg=%0d val=%h",
                      e.req, wb_ok, wb_areg, wb_value, e.flag, e.ar, e.val);
           end
      endcase
      pending--;
    end
  end

  task automatic idle_inputs();
    alloc_valid = 0; fin_en = 0; wb_en = 0; flush = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic exp_lk(input logic [4:0] ar, input logic hit, input logic [TW-1:0] tag,
                        input logic rdy, input logic [31:0] val, input string req);
    @(negedge clk);
    lk_areg = ar;
    push('{0, hit, tag, rdy, val, 5'd0, req});
  endtask

  task automatic do_alloc(input logic [4:0] ar, input logic [TW-1:0] tag, input string req);
    @(negedge clk);
    alloc_valid = 1; alloc_areg = ar;
    push('{1, 1'b1, tag, 1'b0, 32'd0, 5'd0, req});
    tick();
  endtask

  task automatic do_fin(input logic [TW-1:0] tag, input logic [31:0] d);
    @(negedge clk);
    fin_en = 1; fin_tag = tag; fin_data = d;
    tick();
  endtask

  task automatic do_wb(input logic [TW-1:0] tag, input logic ok, input logic [4:0] ar,
                       input logic [31:0] val, input logic fl, input string req);
    @(negedge clk);
    wb_en = 1; wb_tag = tag; flush = fl;
    if (fl) begin
      alloc_valid = 1; alloc_areg = 5'd12;
      push('{1, 1'b0, '0, 1'b0, 32'd0, 5'd0, "R7"});
    end
    push('{2, ok, '0, 1'b0, val, ar, req});
    tick();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        @(negedge clk);
        push('{1, 1'b1, 4'd0, 1'b0, 32'd0, 5'd0, "R1"});
        exp_lk(5'd3, 0, 0, 0, 0, "R1");
        // R2 allocation
        do_alloc(5'd3, 4'd0, "R2");
        exp_lk(5'd3, 1, 4'd0, 0, 0, "R2");
        do_alloc(5'd5, 4'd1, "R2");
        // R4 rename of the same register
        do_alloc(5'd3, 4'd2, "R4");
        exp_lk(5'd3, 1, 4'd2, 0, 0, "R4");
        // R5 finish stale then newest
        do_fin(4'd0, 32'h0000_AAAA);
        exp_lk(5'd3, 1, 4'd2, 0, 0, "R5");
        do_fin(4'd2, 32'h0000_1234);
        exp_lk(5'd3, 1, 4'd2, 1, 32'h0000_1234, "R5");
        // R6 writeback of a pending entry is refused
        do_wb(4'd1, 0, 5'd0, 32'd0, 0, "R6");
        exp_lk(5'd5, 1, 4'd1, 0, 0, "R6");
        // R6 writeback of a done stale entry, then reuse of its slot
        do_wb(4'd0, 1, 5'd3, 32'h0000_AAAA, 0, "R6");
        do_alloc(5'd7, 4'd0, "R6");
        // R10 stray finish on a free entry
        do_fin(4'd5, 32'h0000_0099);
        do_alloc(5'd9, 4'd3, "R2");
        do_alloc(5'd10, 4'd4, "R2");
        do_alloc(5'd11, 4'd5, "R10");
        exp_lk(5'd11, 1, 4'd5, 0, 0, "R10");
        // R9 writeback of the newest entry makes the register miss
        do_wb(4'd2, 1, 5'd3, 32'h0000_1234, 0, "R9");
        exp_lk(5'd3, 0, 0, 0, 0, "R9");
        // fill the pool
        do_alloc(5'd20, 4'd2, "R2");
        for (int i = 6; i < N; i++) do_alloc(5'(15 + i), TW'(i), "R2");
        // R3 full pool stalls and ignores the request
        @(negedge clk);
        alloc_valid = 1; alloc_areg = 5'd12;
        push('{1, 1'b0, '0, 1'b0, 32'd0, 5'd0, "R3"});
        tick();
        exp_lk(5'd12, 0, 0, 0, 0, "R3");
        // R8 writeback and flush in one cycle
        do_fin(4'd1, 32'h0000_0055);
        do_wb(4'd1, 1, 5'd5, 32'h0000_0055, 1, "R8");
        // R7 pool emptied
        exp_lk(5'd7, 0, 0, 0, 0, "R7");
        exp_lk(5'd5, 0, 0, 0, 0, "R7");
        do_alloc(5'd4, 4'd0, "R7");
        exp_lk(5'd4, 1, 4'd0, 0, 0, "R7");
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule